// File: doc/BRIEF.md
# Divide-by-Twelve Two-Section Counter

This block is a 4-bit counter split into two independent sections. The first section divides by two: it toggles bit 0 of the output on every falling edge seen on its own count input. The second section divides by six, in two steps rather than in binary. Bits 2:1 step through a three-state cycle, and bit 3 toggles each time that cycle wraps. The two count inputs and the clear inputs are asynchronous levels. They are brought into the system clock domain through a synchronizer chain, and a falling edge is recognised when successive synchronized samples go from 1 to 0.

A static cascade input chains the sections. When it is set, bit 0 falling drives the second section in the same system cycle, and the second section's own count input is ignored. The chained counter then counts modulo 12. Its code skips the values 6, 7, 14 and 15, and bit 3 becomes a square wave with a 50% duty cycle at one twelfth of the first section's edge rate. A clear acts only while both clear inputs are high: it forces all four bits low and masks every count edge. There is no preset.

States of bits 2:1 equal to 11 cannot be reached from reset. If one ever occurs, it returns to zero on the next step of the second section.

Top module: `div12_counter`

## Requirements
- R1: While rst_ni is low, q_o reads 4'b0000.
- R2: q_o[0] inverts on each falling edge of cp0_i; rising edges of cp0_i leave q_o unchanged.
- R3: With cascade_i low, each falling edge of cp1_i moves q_o[2:1] through 00, 01, 10 and back to 00; q_o[2:1] never reads 11.
- R4: q_o[3] changes only when q_o[2:1] goes from 10 to 00 (or on clear).
- R5: With cascade_i high, successive falling edges of cp0_i from zero give q_o = 0, 1, 2, 3, 4, 5, 8, 9, 10, 11, 12, 13, then 0 again.
- R6: With cascade_i high, q_o[3] is high for exactly 6 of every 12 cp0_i falling edges.
- R7: With cascade_i high, falling edges on cp1_i have no effect on q_o.
- R8: With cascade_i low, cp0_i edges leave q_o[3:1] unchanged and cp1_i edges leave q_o[0] unchanged.
- R9: While clr_a_i and clr_b_i are both high, q_o reads 0 and count edges on either input are ignored.
- R10: With only one of clr_a_i and clr_b_i high, the counter keeps counting.
- R11: q_o changes only as a result of a synchronized count edge or a clear; an edge takes effect on the (SYNC_STAGES+1)-th rising clk_i edge after the input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples all asynchronous inputs |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cp0_i | input | 1 | Count input of the divide-by-two section, acts on falling edges |
| cp1_i | input | 1 | Count input of the divide-by-six section, acts on falling edges |
| clr_a_i | input | 1 | First clear input, clears only together with clr_b_i |
| clr_b_i | input | 1 | Second clear input, clears only together with clr_a_i |
| cascade_i | input | 1 | Static mode input: 1 chains bit 0 into the second section |
| q_o | output | 4 | Counter state: bit 0 from the first section, bits 3:1 from the second |

## Verification
On every cycle the assertions check four things: no output bit changes without a synchronized edge or a clear, bits 2:1 never hold the unused code, bit 3 moves only on the 10-to-00 wrap, and the output is zero after a clear. The scenarios cover what depends on a mode or on a history of edges: the full modulo-12 code with its skipped values and the duty cycle of bit 3, the independence of the two sections when they are not chained, cp1_i being ignored while chained, and a clear applied with only one input high.

// File: rtl/div12_pkg.sv
package div12_pkg;
  localparam int unsigned CNT_W = 4;
  localparam int unsigned PH_W  = 2;

  typedef logic [PH_W-1:0] phase_t;

  localparam phase_t PH_S0 = 2'b00;
  localparam phase_t PH_S1 = 2'b01;
  localparam phase_t PH_S2 = 2'b10;

  typedef struct packed {
    logic   hi;
    phase_t ph;
  } hexa_t;
endpackage

// File: rtl/div12_sync_fall.sv
module div12_sync_fall #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] lvl_o,
  output logic [WIDTH-1:0] fall_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES:0] pipe_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= '0;
      else         pipe_q <= {pipe_q[STAGES-1:0], d_i[g]};
    end

    // last synced sample vs. the one before it
    assign lvl_o[g]  = pipe_q[STAGES-1];
    assign fall_o[g] = pipe_q[STAGES] & ~pipe_q[STAGES-1];
  end
endmodule

// File: rtl/div12_half_stage.sv
module div12_half_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic step_i,
  output logic q_o,
  output logic fall_o
);
  logic q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= 1'b0;
    else if (clr_i)  q_q <= 1'b0;
    else if (step_i) q_q <= ~q_q;
  end

  assign q_o    = q_q;
  // q falls at this edge: feeds the chained section in the same cycle
  assign fall_o = q_q & step_i & ~clr_i;
endmodule

// File: rtl/div12_hexa_stage.sv
module div12_hexa_stage
  import div12_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       step_i,
  output logic [2:0] q_o
);
  hexa_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (clr_i) begin
      st_d = '0;
    end else if (step_i) begin
      unique case (st_q.ph)
        PH_S0: st_d.ph = PH_S1;
        PH_S1: st_d.ph = PH_S2;
        PH_S2: begin
          st_d.ph = PH_S0;
          st_d.hi = ~st_q.hi;
        end
        default: st_d = '0;  // unused x11 recovers to 000
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= st_d;
  end

  assign q_o = {st_q.hi, st_q.ph};
endmodule

// File: rtl/div12_counter.sv
module div12_counter
  import div12_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cp0_i,
  input  logic             cp1_i,
  input  logic             clr_a_i,
  input  logic             clr_b_i,
  input  logic             cascade_i,
  output logic [CNT_W-1:0] q_o
);
  localparam int unsigned IN_W = 4;
  localparam int unsigned IX_CP0 = 0;
  localparam int unsigned IX_CP1 = 1;
  localparam int unsigned IX_CLA = 2;
  localparam int unsigned IX_CLB = 3;

  logic [IN_W-1:0] lvl, fall;
  logic            clr, step_lo, step_hi, lo_fall, lo_q;
  logic [2:0]      hi_q;

  div12_sync_fall #(.WIDTH(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({clr_b_i, clr_a_i, cp1_i, cp0_i}),
    .lvl_o  (lvl),
    .fall_o (fall)
  );

  assign clr     = lvl[IX_CLA] & lvl[IX_CLB];
  assign step_lo = fall[IX_CP0];
  assign step_hi = cascade_i ? lo_fall : fall[IX_CP1];

  div12_half_stage u_lo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .step_i (step_lo),
    .q_o    (lo_q),
    .fall_o (lo_fall)
  );

  div12_hexa_stage u_hi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .step_i (step_hi),
    .q_o    (hi_q)
  );

  assign q_o = {hi_q, lo_q};
endmodule

// File: rtl/div12_counter_chk.sv
module div12_counter_chk #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cp0_i,
  input logic       cp1_i,
  input logic       clr_a_i,
  input logic       clr_b_i,
  input logic       cascade_i,
  input logic [3:0] q_o
);
  logic [SYNC_STAGES:0] p0_q, p1_q;
  logic [SYNC_STAGES-1:0] pa_q, pb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p0_q <= '0; p1_q <= '0; pa_q <= '0; pb_q <= '0;
    end else begin
      p0_q <= {p0_q[SYNC_STAGES-1:0], cp0_i};
      p1_q <= {p1_q[SYNC_STAGES-1:0], cp1_i};
      pa_q <= {pa_q[SYNC_STAGES-2:0], clr_a_i};
      pb_q <= {pb_q[SYNC_STAGES-2:0], clr_b_i};
    end
  end

  logic f0, f1, clr_s;
  assign f0    = p0_q[SYNC_STAGES] & ~p0_q[SYNC_STAGES-1];
  assign f1    = p1_q[SYNC_STAGES] & ~p1_q[SYNC_STAGES-1];
  assign clr_s = pa_q[SYNC_STAGES-1] & pb_q[SYNC_STAGES-1];

  // R1
  always @(posedge clk_i)
    if (!rst_ni) reset_zero_chk: assert (q_o == 4'b0000) else $error("q_o not zero in reset");

  // R11
  q0_needs_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o[0] != $past(q_o[0])) |-> ($past(f0) || $past(clr_s)));

  // R11
  hi_needs_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o[3:1] != $past(q_o[3:1])) |-> ($past(f0) || $past(f1) || $past(clr_s)));

  // R3
  no_unused_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_o[2:1] != 2'b11);

  // R4
  q3_on_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((q_o[3] != $past(q_o[3])) && !$past(clr_s)) |-> ($past(q_o[2:1]) == 2'b10 && q_o[2:1] == 2'b00));

  // R9
  clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clr_s) |-> (q_o == 4'b0000));
endmodule

bind div12_counter div12_counter_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cp0_i     (cp0_i),
  .cp1_i     (cp1_i),
  .clr_a_i   (clr_a_i),
  .clr_b_i   (clr_b_i),
  .cascade_i (cascade_i),
  .q_o       (q_o)
);

// File: tb/div12_counter_tb_top.sv
module div12_counter_tb_top;
  localparam int unsigned SYNC = 2;
  localparam int unsigned LAT  = SYNC + 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cp0_i = 1'b1, cp1_i = 1'b1, clr_a_i = 1'b0, clr_b_i = 1'b0, cascade_i = 1'b0;
  logic [3:0] q_o;

  always #2 clk_i = ~clk_i;

  div12_counter #(.SYNC_STAGES(SYNC)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cp0_i(cp0_i), .cp1_i(cp1_i),
    .clr_a_i(clr_a_i), .clr_b_i(clr_b_i), .cascade_i(cascade_i), .q_o(q_o)
  );

  int checks = 0, errors = 0, hi_seen = 0;
  logic [3:0] exp_q[$];
  string      tag_q[$];

  // reference model
  logic m0 = 1'b0, m3 = 1'b0;
  int   mph = 0;

  function automatic logic [3:0] model_val();
    return {m3, mph == 2, mph == 1, m0};
  endfunction

  function automatic void hexa_step();
    if (mph == 2) begin mph = 0; m3 = ~m3; end
    else mph = mph + 1;
  endfunction

  function automatic void model_clear();
    m0 = 1'b0; m3 = 1'b0; mph = 0;
  endfunction

  task automatic push(input logic [3:0] v, input string t);
    exp_q.push_back(v);
    tag_q.push_back(t);
  endtask

  // monitor
  always @(negedge clk_i) begin
    while (exp_q.size() > 0) begin
      logic [3:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (t == "R5" && q_o[3]) hi_seen++;
      if (q_o !== e) begin
        errors++;
        $display("FAIL %s: q_o=%b expected %b", t, q_o, e);
      end
    end
  end

  task automatic fall_cp0(input string t);
    @(negedge clk_i) cp0_i = 1'b1;
    repeat (LAT) @(negedge clk_i);
    push(model_val(), {t, "_rise"});
    @(negedge clk_i) cp0_i = 1'b0;
    repeat (LAT) @(posedge clk_i);
    if (!(clr_a_i && clr_b_i)) begin
      if (m0) begin m0 = 1'b0; if (cascade_i) hexa_step(); end
      else m0 = 1'b1;
    end
    push(model_val(), t);
  endtask

  task automatic fall_cp1(input string t);
    @(negedge clk_i) cp1_i = 1'b1;
    repeat (LAT) @(negedge clk_i);
    @(negedge clk_i) cp1_i = 1'b0;
    repeat (LAT) @(posedge clk_i);
    if (!(clr_a_i && clr_b_i) && !cascade_i) hexa_step();
    push(model_val(), t);
  endtask

  task automatic do_clear();
    @(negedge clk_i) begin clr_a_i = 1'b1; clr_b_i = 1'b1; end
    repeat (LAT) @(posedge clk_i);
    model_clear();
    push(4'b0000, "R9");
  endtask

  task automatic end_clear();
    @(negedge clk_i) begin clr_a_i = 1'b0; clr_b_i = 1'b0; end
    repeat (LAT) @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [3:0] seq [12] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd8, 4'd9, 4'd10, 4'd11, 4'd12, 4'd13};
    repeat (3) @(posedge clk_i);
    push(4'b0000, "R1");
    @(negedge clk_i) rst_ni = 1'b1;
    repeat (LAT) @(negedge clk_i);

    // R2, R8: first section alone
    for (int i = 0; i < 3; i++) fall_cp0("R2");
    for (int i = 0; i < 4; i++) fall_cp0("R8");
    // R3, R4: second section alone, through two wraps
    for (int i = 0; i < 7; i++) fall_cp1("R3");
    fall_cp1("R4");
    fall_cp1("R8");

    // R9: clear and ignored edges while held
    do_clear();
    fall_cp0("R9");
    fall_cp1("R9");
    end_clear();

    // R10: one clear input alone
    @(negedge clk_i) clr_a_i = 1'b1;
    fall_cp0("R10");
    fall_cp1("R10");
    @(negedge clk_i) begin clr_a_i = 1'b0; clr_b_i = 1'b1; end
    fall_cp0("R10");
    @(negedge clk_i) clr_b_i = 1'b0;

    // R5, R6: cascaded modulo-12 against the code table
    do_clear();
    end_clear();
    @(negedge clk_i) cascade_i = 1'b1;
    repeat (LAT) @(negedge clk_i);
    for (int n = 1; n <= 24; n++) begin
      fall_cp0("R5");
      if (model_val() != seq[n % 12]) begin
        errors++;
        $display("FAIL R5: model=%0d expected %0d", model_val(), seq[n % 12]);
      end
    end
    @(negedge clk_i);
    checks++;
    if (hi_seen != 12) begin
      errors++;
      $display("FAIL R6: q3 high count=%0d expected 12", hi_seen);
    end

    // R7: cp1 ignored while cascaded
    fall_cp0("R5");
    fall_cp1("R7");
    fall_cp1("R7");

    repeat (4) @(negedge clk_i);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule